// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This unit watches the already-synchronized input levels of a GPIO bank of up to 32 pins. It records every armed level change as a sticky cause bit. Each pin can be armed for a low-to-high change, a high-to-low change, or both, through two independent enable masks. Software sees the pending causes through a readback that is already filtered by an event enable mask. It acknowledges causes by writing ones to a clear register.

Every pending cause that passes the event enable mask feeds one registered, shared interrupt line. The unit has a simple synchronous register port: one write strobe, an address and write data, plus a combinational read data output. Only edge sensing exists. Pad synchronization is done before the pins arrive here.

Register offsets on the port: rise enable 0x44, fall enable 0x48, masked cause readback 0x80 (read-only), event enable 0x94, cause clear 0x98 (write-only). Bit i of every register belongs to pin i.

Top module: `gpio_edge_cause`

## Requirements
- R1: After reset, the rise enable, fall enable and event enable masks, all cause bits and `irq_o` are 0.
- R2: A pin whose previous sampled level was 0 and whose current level is 1, with its bit set in the rise enable mask (0x44), sets its cause bit at that clock edge.
- R3: A 1-to-0 change on a pin whose fall enable bit (0x48) is set sets its cause bit. With both enable bits set, either direction sets it.
- R4: A level change in a direction that is not enabled for that pin leaves its cause bit unchanged. A pin that does not change sets nothing.
- R5: A cause bit, once set, stays set whatever the pin does afterwards, until it is cleared.
- R6: A write to 0x98 clears exactly the cause bits whose written data bit is 1. Cause bits written with 0 keep their value.
- R7: If an armed edge and a clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: The masks at 0x44, 0x48 and 0x94 read back the last value written. A read of 0x80 returns the cause bits ANDed with the event enable mask.
- R9: `irq_o` is 1 exactly one clock after the OR of all masked causes is 1, and 0 one clock after it is 0.
- R10: Clearing an event enable bit removes that pin from the readback and the interrupt. It does not erase the stored cause, which reappears when the bit is enabled again.
- R11: A write to any address other than 0x44, 0x48, 0x94 or 0x98 changes no state. A read of any address other than 0x44, 0x48, 0x80 or 0x94 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that `pin_lvl` is already synchronous to `clk`. They also assume that a single write strobe carries one address per cycle, so the clear vector and the mask updates never come from two writes at once. The bench changes pins and write strobes only on the falling clock edge, never holds the strobe longer than one cycle, and reads with the strobe low. Pins that are not armed are toggled on purpose to show that they leave no cause. Same-cycle collisions between an edge and a clear are built on purpose rather than left to chance.

// File: rtl/gpec_pkg.sv
package gpec_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RISE_EN = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN  = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h98;

  // armed edge per pin: up-going with rise arm, down-going with fall arm
  function automatic logic f_edge_hit(input logic cur, input logic prev,
                                      input logic rarm, input logic farm);
    return (cur & ~prev & rarm) | (~cur & prev & farm);
  endfunction

  // sticky update; a fresh edge outranks an acknowledge on the same bit
  function automatic logic [BUS_W-1:0] f_cause_next(input logic [BUS_W-1:0] cause,
                                                    input logic [BUS_W-1:0] hit,
                                                    input logic [BUS_W-1:0] ack);
    return (cause & ~ack) | hit;
  endfunction
endpackage

// File: rtl/gpec_edge.sv
module gpec_edge #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  output logic [NPINS-1:0] hit_o
);
  import gpec_pkg::*;

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_lvl;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit_o[g] = f_edge_hit(pin_lvl[g], prev_q[g], rise_en[g], fall_en[g]);
  end

  // an event never appears on a pin whose level did not change
  p_hit_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ~(pin_lvl ^ prev_q)) == '0));
  // an up-going hit needs the rise arm, a down-going hit the fall arm
  p_hit_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & pin_lvl & ~rise_en) == '0) && ((hit_o & ~pin_lvl & ~fall_en) == '0));
endmodule

// File: rtl/gpec_regs.sv
module gpec_regs #(
  parameter int unsigned NPINS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [gpec_pkg::ADDR_W-1:0]  addr,
  input  logic [gpec_pkg::BUS_W-1:0]   wdata,
  input  logic [NPINS-1:0]             masked_i,
  output logic [NPINS-1:0]             rise_en_o,
  output logic [NPINS-1:0]             fall_en_o,
  output logic [NPINS-1:0]             evt_en_o,
  output logic [NPINS-1:0]             ack_o,
  output logic [gpec_pkg::BUS_W-1:0]   rdata_o
);
  import gpec_pkg::*;

  logic [NPINS-1:0] wbits;
  logic             wr_rise, wr_fall, wr_evt, wr_ack, known_rd;

  assign wbits   = wdata[NPINS-1:0];
  assign wr_rise = wr_en && (addr == OFS_RISE_EN);
  assign wr_fall = wr_en && (addr == OFS_FALL_EN);
  assign wr_evt  = wr_en && (addr == OFS_EVT_EN);
  assign wr_ack  = wr_en && (addr == OFS_ACK);
  assign ack_o   = wr_ack ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      evt_en_o  <= '0;
    end else begin
      if (wr_rise) rise_en_o <= wbits;
      if (wr_fall) fall_en_o <= wbits;
      if (wr_evt)  evt_en_o  <= wbits;
    end
  end

  always_comb begin
    rdata_o  = '0;
    known_rd = 1'b1;
    case (addr)
      OFS_RISE_EN: rdata_o = BUS_W'(rise_en_o);
      OFS_FALL_EN: rdata_o = BUS_W'(fall_en_o);
      OFS_EVT_EN:  rdata_o = BUS_W'(evt_en_o);
      OFS_PEND:    rdata_o = BUS_W'(masked_i);
      default:     known_rd = 1'b0;
    endcase
  end

  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> (rise_en_o == $past(wbits)));
  p_evt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (evt_en_o == $past(wbits)));
  p_stray_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_rise && !wr_fall && !wr_evt) |=>
      ($stable(rise_en_o) && $stable(fall_en_o) && $stable(evt_en_o)));
  p_stray_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !known_rd |-> (rdata_o == '0));
endmodule

// File: rtl/gpec_cause.sv
module gpec_cause #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit_i,
  input  logic [NPINS-1:0] ack_i,
  input  logic [NPINS-1:0] evt_en_i,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);
  import gpec_pkg::*;

  logic [NPINS-1:0] cause_q;
  logic [BUS_W-1:0] cause_nxt;
  logic             any_pend;

  assign cause_nxt = f_cause_next(BUS_W'(cause_q), BUS_W'(hit_i), BUS_W'(ack_i));
  assign masked_o  = cause_q & evt_en_i;
  assign any_pend  = |masked_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      cause_q <= cause_nxt[NPINS-1:0];
      irq_o   <= any_pend;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cause_q == '0 && !irq_o));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(cause_q) & ~$past(ack_i)) & ~cause_q) == '0));
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(hit_i)) == '0));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & ~hit_i)) |=> ((cause_q & $past(ack_i & ~hit_i)) == '0));
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((cause_q & $past(hit_i)) == $past(hit_i)));
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> irq_o);
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !irq_o);
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int unsigned NPINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPINS-1:0]            pin_lvl,
  input  logic                        reg_wr_en,
  input  logic [gpec_pkg::ADDR_W-1:0] reg_addr,
  input  logic [gpec_pkg::BUS_W-1:0]  reg_wdata,
  output logic [gpec_pkg::BUS_W-1:0]  reg_rdata,
  output logic                        irq_o
);
  import gpec_pkg::*;

  initial begin
    if (NPINS < 1 || NPINS > BUS_W) $error("NPINS must be 1..%0d", BUS_W);
  end

  logic [NPINS-1:0] rise_en, fall_en, evt_en, ack_vec, hit_vec, masked;

  gpec_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .masked_i(masked), .rise_en_o(rise_en),
    .fall_en_o(fall_en), .evt_en_o(evt_en), .ack_o(ack_vec),
    .rdata_o(reg_rdata)
  );

  gpec_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .rise_en(rise_en),
    .fall_en(fall_en), .hit_o(hit_vec)
  );

  gpec_cause #(.NPINS(NPINS)) u_cause (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_vec), .ack_i(ack_vec),
    .evt_en_i(evt_en), .masked_o(masked), .irq_o(irq_o)
  );

  // a mask cleared at the register port silences the line within two clocks
  p_evt_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_EVT_EN && reg_wdata == '0) |=> ##1 !irq_o);
endmodule

// File: tb/gpio_edge_cause_tb.sv
`timescale 1ns/1ps
module gpio_edge_cause_tb;
  localparam logic [7:0] A_RISE = 8'h44, A_FALL = 8'h48, A_PEND = 8'h80,
                         A_EVT = 8'h94, A_ACK = 8'h98;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_cause u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic setp(input logic [31:0] v);
    @(negedge clk);
    pin_lvl = v;
    @(negedge clk);
  endtask

  task automatic clean();
    wr(A_RISE, '0); wr(A_FALL, '0); wr(A_EVT, '0); wr(A_ACK, '1);
    tick(); tick();
  endtask

  task automatic t_reset();
    rd_check("R1 rise mask", A_RISE, '0);
    rd_check("R1 fall mask", A_FALL, '0);
    rd_check("R1 evt mask", A_EVT, '0);
    wr(A_EVT, '1);
    rd_check("R1 causes", A_PEND, '0);
    check("R1 irq", {31'd0, irq_o}, '0);
    clean();
  endtask

  task automatic t_masks();
    wr(A_RISE, 32'hA5A5_0F0F); wr(A_FALL, 32'h1234_5678); wr(A_EVT, 32'hFFFF_0000);
    rd_check("R8 rise readback", A_RISE, 32'hA5A5_0F0F);
    rd_check("R8 fall readback", A_FALL, 32'h1234_5678);
    rd_check("R8 evt readback", A_EVT, 32'hFFFF_0000);
    clean();
  endtask

  task automatic t_rise();
    wr(A_RISE, 32'h1); wr(A_EVT, '1);
    setp(pin_lvl | 32'h1);
    rd_check("R2 rise sets", A_PEND, 32'h1);
    setp(pin_lvl & ~32'h1);
    rd_check("R5 sticky after fall", A_PEND, 32'h1);
    wr(A_ACK, 32'h1);
    rd_check("R6 cleared", A_PEND, 32'h0);
    setp(pin_lvl | 32'h1);
    setp(pin_lvl & ~32'h1);
    wr(A_ACK, 32'h1);
    setp(pin_lvl | 32'h1);
    wr(A_ACK, 32'h1);
    setp(pin_lvl & ~32'h1);
    rd_check("R4 fall not armed", A_PEND, 32'h0);
    clean();
  endtask

  task automatic t_fall();
    wr(A_FALL, 32'h20); wr(A_EVT, '1);
    setp(pin_lvl | 32'h20);
    rd_check("R4 rise on fall-only pin", A_PEND, 32'h0);
    setp(pin_lvl & ~32'h20);
    rd_check("R3 fall sets", A_PEND, 32'h20);
    clean();
  endtask

  task automatic t_both();
    wr(A_RISE, 32'h200); wr(A_FALL, 32'h200); wr(A_EVT, '1);
    setp(pin_lvl | 32'h200);
    rd_check("R3 both: rise", A_PEND, 32'h200);
    wr(A_ACK, 32'h200);
    rd_check("R6 both cleared", A_PEND, 32'h0);
    setp(pin_lvl & ~32'h200);
    rd_check("R3 both: fall", A_PEND, 32'h200);
    clean();
  endtask

  task automatic t_unarmed();
    wr(A_EVT, '1);
    setp(pin_lvl ^ 32'h0000_00FF);
    setp(pin_lvl ^ 32'h0000_00FF);
    tick();
    rd_check("R4 unarmed toggles", A_PEND, 32'h0);
    check("R4 unarmed irq", {31'd0, irq_o}, '0);
    clean();
  endtask

  task automatic t_partial_ack();
    wr(A_RISE, 32'h6); wr(A_EVT, '1);
    setp(pin_lvl | 32'h6);
    rd_check("R2 two pins", A_PEND, 32'h6);
    wr(A_ACK, 32'h2);
    rd_check("R6 partial ack", A_PEND, 32'h4);
    clean();
  endtask

  task automatic t_collision();
    wr(A_RISE, 32'h18); wr(A_EVT, '1);
    setp(pin_lvl | 32'h18);
    setp(pin_lvl & ~32'h18);
    rd_check("R5 pre-collision", A_PEND, 32'h18);
    @(negedge clk);
    pin_lvl = pin_lvl | 32'h08;
    reg_wr_en = 1'b1; reg_addr = A_ACK; reg_wdata = 32'h18;
    @(negedge clk);
    reg_wr_en = 1'b0;
    rd_check("R7 edge beats ack", A_PEND, 32'h08);
    clean();
  endtask

  task automatic t_irq_timing();
    wr(A_RISE, 32'h80); wr(A_EVT, '1);
    setp(pin_lvl | 32'h80);
    rd_check("R2 bit7", A_PEND, 32'h80);
    check("R9 irq not yet", {31'd0, irq_o}, '0);
    tick();
    check("R9 irq one clock later", {31'd0, irq_o}, 32'h1);
    wr(A_ACK, 32'h80);
    check("R9 irq lags ack", {31'd0, irq_o}, 32'h1);
    tick();
    check("R9 irq drops", {31'd0, irq_o}, '0);
    clean();
  endtask

  task automatic t_evt_mask();
    wr(A_RISE, 32'h800); wr(A_EVT, 32'h800);
    setp(pin_lvl | 32'h800);
    tick();
    check("R9 irq with event enable", {31'd0, irq_o}, 32'h1);
    wr(A_EVT, '0);
    rd_check("R10 masked readback", A_PEND, 32'h0);
    tick();
    check("R10 irq masked", {31'd0, irq_o}, '0);
    wr(A_EVT, 32'h800);
    rd_check("R10 cause kept", A_PEND, 32'h800);
    clean();
  endtask

  task automatic t_stray();
    wr(A_RISE, 32'h0F); wr(A_FALL, 32'hF0); wr(A_EVT, 32'hFF);
    wr(8'h10, '1); wr(A_PEND, '1); wr(8'h44 + 8'h01, '1);
    rd_check("R11 rise untouched", A_RISE, 32'h0F);
    rd_check("R11 fall untouched", A_FALL, 32'hF0);
    rd_check("R11 evt untouched", A_EVT, 32'hFF);
    rd_check("R11 no cause from pend write", A_PEND, 32'h0);
    rd_check("R11 unmapped read", 8'h10, 32'h0);
    rd_check("R11 ack reads zero", A_ACK, 32'h0);
    clean();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_masks();
    t_rise();
    t_fall();
    t_both();
    t_unarmed();
    t_partial_ack();
    t_collision();
    t_irq_timing();
    t_evt_mask();
    t_stray();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule